// File: doc/BRIEF.md
# Proximity Tag Anticollision Controller

This block is the command-level controller of a proximity tag. A frame receiver upstream delivers the bytes of each request that has already passed its checksum. It strobes one byte per cycle and then gives a frame-end pulse. The block keeps the tag's life-cycle state and an 8-bit tag identifier whose low nibble acts as the anticollision slot number. For every frame it decides whether the tag answers, what kind of answer the transmitter must send, and which memory read or write to request.

Random values come from a free-running 16-bit linear-feedback shift register. Its current value is used on the cycle the frame-end pulse arrives. A reader separates many tags in three ways: it has them re-draw a 4-bit slot on a poll, it calls each slot in turn, and it then addresses one tag at a time by its identifier. The life-cycle state decides which commands a tag accepts at each point in this sequence.

All decisions are registered. The state, the identifier and every request or answer output change on the clock edge that samples the frame-end pulse. Answer and memory request outputs are single-cycle pulses.

Top module: `tag_anticoll_ctrl`

## Requirements
- R1: After reset the state reads Ready (code 0), the identifier equals the low byte of the random seed (default E1h), and no answer or memory request is pulsed. State codes are Ready 0, Inventory 1, Selected 2, Deselected 3, Deactivated 4.
- R2: In Ready, every frame other than the two-byte wake command (06h 00h) leaves the state and identifier unchanged and produces no output pulse.
- R3: The wake command from Ready or Inventory moves to Inventory. It loads the identifier with bits 7..0 of the random register as it stood in the frame-end cycle, and answers with kind 1 (identifier), length 1, carrying the new identifier. The random register is a right-shifting Galois LFSR with feedback mask B400h, seeded with ACE1h at reset and advancing every cycle.
- R4: The slot poll (06h 04h) is honoured only in Inventory. It replaces identifier bits 3..0 with bits 3..0 of the random register and keeps bits 7..4. It answers with the identifier only when the new nibble is 0.
- R5: A one-byte slot call has low nibble 6h and a slot number 1..15 in the high nibble. In Inventory it answers with the identifier exactly when that slot number equals identifier bits 3..0. Otherwise it does nothing.
- R6: The select command is 0Eh followed by an identifier byte. On a match in Inventory, Deselected or Selected, the state becomes Selected and the identifier is echoed. On a mismatch in Selected, the state becomes Deselected. On a mismatch in any other state, nothing changes.
- R7: The retire command (0Fh) moves Selected to Deactivated without an answer. Deactivated ignores every later frame.
- R8: The return command (0Ch) moves Selected to Inventory without an answer and is ignored elsewhere. Selected ignores the wake and slot-poll commands.
- R9: The block read (08h, address) is honoured only in Selected. Addresses 0..63 and 255 pulse a memory read with that address and an answer of kind 2, length 4. Addresses 64..127 give an answer of kind 3 (filler), length 4, without a memory read. Any other address gives no pulse.
- R10: The block write (09h, address, four data bytes least significant first) is honoured only in Selected. It pulses a memory write with the address and the assembled 32-bit word, and never answers.
- R11: The identity read (0Bh) is honoured only in Selected and answers with kind 4, length 8.
- R12: A frame whose byte count differs from its command's length (wake, poll and select 2 bytes; slot call, retire, return and identity read 1; read 2; write 6) is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| rx_valid | input | 1 | One request byte is present this cycle |
| rx_byte | input | 8 | Request byte |
| rx_done | input | 1 | Frame end, frame already validated |
| tag_state | output | 3 | Current life-cycle state code |
| chip_id | output | 8 | Current tag identifier |
| resp_valid | output | 1 | Answer to be sent (one-cycle pulse) |
| resp_kind | output | 3 | Answer kind: 1 identifier, 2 block data, 3 filler, 4 identity |
| resp_len | output | 4 | Answer payload length in bytes |
| resp_id | output | 8 | Identifier byte for kind-1 answers |
| mem_rd | output | 1 | Memory block read request (pulse) |
| mem_wr | output | 1 | Memory block write request (pulse) |
| mem_addr | output | 8 | Block address for the request |
| mem_wdata | output | 32 | Write data |

## Verification
A wrong state register shows on the very next frame. A tag stuck in or wrongly left in Selected answers block reads that it should ignore, or stays silent on them. A wrong return to Ready or Inventory changes how the tag reacts to the wake and slot commands. A corrupted identifier or slot nibble shows as a wrong echo value, or as an answer in the wrong slot call. Every such divergence therefore appears one cycle after the frame-end pulse of the first command that depends on it.

// File: rtl/tag_ac_pkg.sv
package tag_ac_pkg;

    typedef enum logic [2:0] {
        ST_READY       = 3'd0,
        ST_INVENTORY   = 3'd1,
        ST_SELECTED    = 3'd2,
        ST_DESELECTED  = 3'd3,
        ST_DEACTIVATED = 3'd4
    } tag_state_e;

    typedef enum logic [2:0] {
        RSP_NONE  = 3'd0,
        RSP_ID    = 3'd1,
        RSP_BLOCK = 3'd2,
        RSP_FILL  = 3'd3,
        RSP_UID   = 3'd4
    } rsp_kind_e;

    localparam logic [7:0] OP_POLL      = 8'h06;
    localparam logic [7:0] POLL_WAKE    = 8'h00;
    localparam logic [7:0] POLL_SLOTS   = 8'h04;
    localparam logic [3:0] SLOT_CALL_LO = 4'h6;
    localparam logic [7:0] OP_SELECT    = 8'h0E;
    localparam logic [7:0] OP_RETIRE    = 8'h0F;
    localparam logic [7:0] OP_RETURN    = 8'h0C;
    localparam logic [7:0] OP_READ      = 8'h08;
    localparam logic [7:0] OP_WRITE     = 8'h09;
    localparam logic [7:0] OP_IDENT     = 8'h0B;

    localparam int BLOCK_BYTES = 4;
    localparam int IDENT_BYTES = 8;
    localparam int MAX_FRAME   = 2 + BLOCK_BYTES;

    typedef struct packed {
        logic        rsp_valid;
        rsp_kind_e   kind;
        logic [3:0]  len;
        logic [7:0]  id;
        logic        rd;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
    } tag_action_t;

    function automatic logic addr_backed(input logic [7:0] a);
        return (a < 8'd64) || (a == 8'hFF);
    endfunction

    function automatic logic addr_filler(input logic [7:0] a);
        return (a >= 8'd64) && (a < 8'd128);
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] s, input logic [15:0] mask);
        return (s >> 1) ^ (s[0] ? mask : 16'h0000);
    endfunction

endpackage

// File: rtl/tag_lfsr.sv
module tag_lfsr #(
    parameter logic [15:0] MASK = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] value
);
    import tag_ac_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) value <= SEED;
        else     value <= lfsr_next(value, MASK);
    end
endmodule

// File: rtl/tag_rx_collect.sv
module tag_rx_collect #(
    parameter int MAX_BYTES = 6,
    localparam int LW = $clog2(MAX_BYTES + 2)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          byte_valid,
    input  logic [7:0]                    byte_data,
    input  logic                          frame_done,
    output logic [MAX_BYTES-1:0][7:0]     frame_bytes,
    output logic [LW-1:0]                 frame_len
);
    localparam logic [LW-1:0] LEN_SAT = LW'(MAX_BYTES + 1);

    always_ff @(posedge clk) begin
        if (rst || frame_done)             frame_len <= '0;
        else if (byte_valid && frame_len != LEN_SAT) frame_len <= frame_len + 1'b1;
    end

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                frame_bytes[g] <= '0;
            else if (byte_valid && !frame_done && frame_len == LW'(g))
                frame_bytes[g] <= byte_data;
        end
    end
endmodule

// File: rtl/tag_cmd_decode.sv
module tag_cmd_decode #(
    parameter int MAX_BYTES = 6,
    localparam int LW = $clog2(MAX_BYTES + 2)
) (
    input  tag_ac_pkg::tag_state_e        state,
    input  logic [7:0]                    chip,
    input  logic [15:0]                   rnd,
    input  logic [MAX_BYTES-1:0][7:0]     fb,
    input  logic [LW-1:0]                 flen,
    output tag_ac_pkg::tag_state_e        nxt_state,
    output logic [7:0]                    nxt_chip,
    output tag_ac_pkg::tag_action_t       act
);
    import tag_ac_pkg::*;

    logic len1, len2, len_wr;
    logic [7:0] b0, b1;

    assign len1   = (flen == LW'(1));
    assign len2   = (flen == LW'(2));
    assign len_wr = (flen == LW'(2 + BLOCK_BYTES));
    assign b0     = fb[0];
    assign b1     = fb[1];

    always_comb begin
        nxt_state = state;
        nxt_chip  = chip;
        act       = '0;
        if (state != ST_DEACTIVATED) begin
            if (b0 == OP_POLL && len2) begin
                if (b1 == POLL_WAKE && (state == ST_READY || state == ST_INVENTORY)) begin
                    nxt_state     = ST_INVENTORY;
                    nxt_chip      = rnd[7:0];
                    act.rsp_valid = 1'b1;
                    act.kind      = RSP_ID;
                    act.len       = 4'd1;
                    act.id        = rnd[7:0];
                end else if (b1 == POLL_SLOTS && state == ST_INVENTORY) begin
                    nxt_chip = {chip[7:4], rnd[3:0]};
                    if (rnd[3:0] == 4'd0) begin
                        act.rsp_valid = 1'b1;
                        act.kind      = RSP_ID;
                        act.len       = 4'd1;
                        act.id        = {chip[7:4], 4'd0};
                    end
                end
            end else if (b0[3:0] == SLOT_CALL_LO && b0[7:4] != 4'd0 && len1) begin
                if (state == ST_INVENTORY && chip[3:0] == b0[7:4]) begin
                    act.rsp_valid = 1'b1;
                    act.kind      = RSP_ID;
                    act.len       = 4'd1;
                    act.id        = chip;
                end
            end else if (b0 == OP_SELECT && len2) begin
                if (b1 == chip) begin
                    if (state != ST_READY) begin
                        nxt_state     = ST_SELECTED;
                        act.rsp_valid = 1'b1;
                        act.kind      = RSP_ID;
                        act.len       = 4'd1;
                        act.id        = chip;
                    end
                end else if (state == ST_SELECTED) begin
                    nxt_state = ST_DESELECTED;
                end
            end else if (state == ST_SELECTED) begin
                if (b0 == OP_RETIRE && len1) begin
                    nxt_state = ST_DEACTIVATED;
                end else if (b0 == OP_RETURN && len1) begin
                    nxt_state = ST_INVENTORY;
                end else if (b0 == OP_READ && len2) begin
                    if (addr_backed(b1)) begin
                        act.rd        = 1'b1;
                        act.addr      = b1;
                        act.rsp_valid = 1'b1;
                        act.kind      = RSP_BLOCK;
                        act.len       = 4'(BLOCK_BYTES);
                    end else if (addr_filler(b1)) begin
                        act.rsp_valid = 1'b1;
                        act.kind      = RSP_FILL;
                        act.len       = 4'(BLOCK_BYTES);
                    end
                end else if (b0 == OP_WRITE && len_wr) begin
                    act.wr    = 1'b1;
                    act.addr  = b1;
                    act.wdata = {fb[5], fb[4], fb[3], fb[2]};
                end else if (b0 == OP_IDENT && len1) begin
                    act.rsp_valid = 1'b1;
                    act.kind      = RSP_UID;
                    act.len       = 4'(IDENT_BYTES);
                end
            end
        end
    end
endmodule

// File: rtl/tag_anticoll_ctrl.sv
module tag_anticoll_ctrl #(
    parameter logic [15:0] LFSR_MASK = 16'hB400,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_done,
    output logic [2:0]  tag_state,
    output logic [7:0]  chip_id,
    output logic        resp_valid,
    output logic [2:0]  resp_kind,
    output logic [3:0]  resp_len,
    output logic [7:0]  resp_id,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [7:0]  mem_addr,
    output logic [31:0] mem_wdata
);
    import tag_ac_pkg::*;

    localparam int LW = $clog2(MAX_FRAME + 2);

    logic [15:0]                  rnd;
    logic [MAX_FRAME-1:0][7:0]    fb;
    logic [LW-1:0]                flen;
    tag_state_e                   state_q, state_d;
    logic [7:0]                   chip_q, chip_d;
    tag_action_t                  act_d, act_q;

    tag_lfsr #(.MASK(LFSR_MASK), .SEED(LFSR_SEED)) u_lfsr (
        .clk(clk), .rst(rst), .value(rnd)
    );

    tag_rx_collect #(.MAX_BYTES(MAX_FRAME)) u_rx (
        .clk(clk), .rst(rst), .byte_valid(rx_valid), .byte_data(rx_byte),
        .frame_done(rx_done), .frame_bytes(fb), .frame_len(flen)
    );

    tag_cmd_decode #(.MAX_BYTES(MAX_FRAME)) u_dec (
        .state(state_q), .chip(chip_q), .rnd(rnd), .fb(fb), .flen(flen),
        .nxt_state(state_d), .nxt_chip(chip_d), .act(act_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            chip_q  <= LFSR_SEED[7:0];
            act_q   <= '0;
        end else if (rx_done) begin
            state_q <= state_d;
            chip_q  <= chip_d;
            act_q   <= act_d;
        end else begin
            act_q   <= '0;
        end
    end

    assign tag_state  = state_q;
    assign chip_id    = chip_q;
    assign resp_valid = act_q.rsp_valid;
    assign resp_kind  = act_q.kind;
    assign resp_len   = act_q.len;
    assign resp_id    = act_q.id;
    assign mem_rd     = act_q.rd;
    assign mem_wr     = act_q.wr;
    assign mem_addr   = act_q.addr;
    assign mem_wdata  = act_q.wdata;
endmodule

// File: rtl/tag_anticoll_chk.sv
module tag_anticoll_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] tag_state,
    input logic [7:0] chip_id,
    input logic       resp_valid,
    input logic [2:0] resp_kind,
    input logic [3:0] resp_len,
    input logic [7:0] resp_id,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic [7:0] mem_addr
);
    a_r7_deactivated_sticky: assert property (@(posedge clk) disable iff (rst)
        (tag_state == 3'd4) |=> (tag_state == 3'd4));

    a_r2_ready_exits_to_inventory: assert property (@(posedge clk) disable iff (rst)
        (tag_state == 3'd0) |=> (tag_state == 3'd0 || tag_state == 3'd1));

    a_r10_write_silent: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> !resp_valid && !mem_rd);

    a_r9_read_range: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> ((mem_addr < 8'd64) || (mem_addr == 8'hFF)));

    a_r6_echo_is_identifier: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == 3'd1) |-> (resp_id == chip_id && resp_len == 4'd1));

    a_r8_memory_answers_when_selected: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind != 3'd1) |-> (tag_state == 3'd2));

    a_r11_ident_length: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_kind == 3'd4) |-> (resp_len == 4'd8));

    a_r3_answer_has_kind: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_kind != 3'd0));
endmodule

bind tag_anticoll_ctrl tag_anticoll_chk u_chk (
    .clk(clk), .rst(rst), .tag_state(tag_state), .chip_id(chip_id),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_len(resp_len),
    .resp_id(resp_id), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr)
);

// File: tb/tb_tag_anticoll_ctrl.sv
module tb_tag_anticoll_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_done = 1'b0;
    logic [2:0]  tag_state;
    logic [7:0]  chip_id;
    logic        resp_valid;
    logic [2:0]  resp_kind;
    logic [3:0]  resp_len;
    logic [7:0]  resp_id;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] m_lfsr;
    logic [15:0] cap;
    logic [7:0]  exp_chip;

    always #4 clk = ~clk;

    tag_anticoll_ctrl dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_done(rx_done),
        .tag_state(tag_state), .chip_id(chip_id), .resp_valid(resp_valid),
        .resp_kind(resp_kind), .resp_len(resp_len), .resp_id(resp_id),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // reference random source from R3
    always @(posedge clk) begin
        if (rst) m_lfsr <= 16'hACE1;
        else     m_lfsr <= (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // cond: 0 none, 1 random nibble zero, 2 random nibble nonzero at frame end
    task automatic send(input int n, input int cond,
                        input logic [7:0] b0 = 8'h00, input logic [7:0] b1 = 8'h00,
                        input logic [7:0] b2 = 8'h00, input logic [7:0] b3 = 8'h00,
                        input logic [7:0] b4 = 8'h00, input logic [7:0] b5 = 8'h00);
        logic [7:0] bb [6];
        bb = '{b0, b1, b2, b3, b4, b5};
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = bb[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        while (!(cond == 0 || (cond == 1 && m_lfsr[3:0] == 4'd0) ||
                 (cond == 2 && m_lfsr[3:0] != 4'd0)))
            @(negedge clk);
        rx_done = 1'b1;
        cap     = m_lfsr;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input logic [2:0] st);
        check(req, "state", tag_state, st);
        check(req, "chip_id", chip_id, exp_chip);
        check(req, "resp_valid", resp_valid, 0);
        check(req, "mem_rd", mem_rd, 0);
        check(req, "mem_wr", mem_wr, 0);
    endtask

    task automatic expect_id(input string req, input logic [2:0] st);
        check(req, "state", tag_state, st);
        check(req, "chip_id", chip_id, exp_chip);
        check(req, "resp_valid", resp_valid, 1);
        check(req, "resp_kind", resp_kind, 1);
        check(req, "resp_len", resp_len, 1);
        check(req, "resp_id", resp_id, exp_chip);
    endtask

    task automatic t_reset;
        exp_chip = 8'hE1;
        expect_quiet("R1", 3'd0);
    endtask

    task automatic t_ready_ignores;
        send(2, 0, 8'h06, 8'h04);      expect_quiet("R2", 3'd0);
        send(2, 0, 8'h0E, 8'hE1);      expect_quiet("R2", 3'd0);
        send(2, 0, 8'h08, 8'h00);      expect_quiet("R2", 3'd0);
        send(1, 0, 8'h0B);             expect_quiet("R2", 3'd0);
    endtask

    task automatic t_wake;
        send(3, 0, 8'h06, 8'h00, 8'h00); expect_quiet("R12", 3'd0);
        send(1, 0, 8'h06);               expect_quiet("R12", 3'd0);
        send(2, 0, 8'h06, 8'h00);
        exp_chip = cap[7:0];
        expect_id("R3", 3'd1);
        send(2, 0, 8'h06, 8'h00);
        exp_chip = cap[7:0];
        expect_id("R3", 3'd1);
    endtask

    task automatic t_slots;
        logic [3:0] wrong;
        send(2, 2, 8'h06, 8'h04);
        exp_chip = {exp_chip[7:4], cap[3:0]};
        expect_quiet("R4", 3'd1);
        wrong = (exp_chip[3:0] == 4'hF) ? 4'h1 : exp_chip[3:0] + 4'h1;
        send(1, 0, {wrong, 4'h6});          expect_quiet("R5", 3'd1);
        send(2, 0, {exp_chip[3:0], 4'h6});  expect_quiet("R12", 3'd1);
        send(1, 0, {exp_chip[3:0], 4'h6});  expect_id("R5", 3'd1);
        send(2, 1, 8'h06, 8'h04);
        exp_chip = {exp_chip[7:4], 4'h0};
        expect_id("R4", 3'd1);
    endtask

    task automatic t_select;
        send(2, 0, 8'h0E, exp_chip ^ 8'h5A); expect_quiet("R6", 3'd1);
        send(1, 0, 8'h0C);                    expect_quiet("R8", 3'd1);
        send(2, 0, 8'h0E, exp_chip);          expect_id("R6", 3'd2);
        send(2, 0, 8'h06, 8'h00);             expect_quiet("R8", 3'd2);
        send(2, 0, 8'h06, 8'h04);             expect_quiet("R8", 3'd2);
    endtask

    task automatic t_memory;
        send(2, 0, 8'h08, 8'h05);
        check("R9", "mem_rd", mem_rd, 1);   check("R9", "mem_addr", mem_addr, 8'h05);
        check("R9", "resp_kind", resp_kind, 2); check("R9", "resp_len", resp_len, 4);
        send(2, 0, 8'h08, 8'hFF);
        check("R9", "mem_rd", mem_rd, 1);   check("R9", "mem_addr", mem_addr, 8'hFF);
        send(2, 0, 8'h08, 8'h50);
        check("R9", "mem_rd", mem_rd, 0);   check("R9", "resp_valid", resp_valid, 1);
        check("R9", "resp_kind", resp_kind, 3); check("R9", "resp_len", resp_len, 4);
        send(2, 0, 8'h08, 8'h90);           expect_quiet("R9", 3'd2);
        send(6, 0, 8'h09, 8'h07, 8'h11, 8'h22, 8'h33, 8'h44);
        check("R10", "mem_wr", mem_wr, 1);  check("R10", "mem_addr", mem_addr, 8'h07);
        check("R10", "mem_wdata", mem_wdata, 32'h44332211);
        check("R10", "resp_valid", resp_valid, 0);
        send(5, 0, 8'h09, 8'h07, 8'h11, 8'h22, 8'h33); expect_quiet("R12", 3'd2);
        send(1, 0, 8'h0B);
        check("R11", "resp_valid", resp_valid, 1);
        check("R11", "resp_kind", resp_kind, 4); check("R11", "resp_len", resp_len, 8);
    endtask

    task automatic t_lifecycle;
        send(1, 0, 8'h0C);                    expect_quiet("R8", 3'd1);
        send(2, 0, 8'h0E, exp_chip);          expect_id("R6", 3'd2);
        send(2, 0, 8'h0E, exp_chip ^ 8'h01);  expect_quiet("R6", 3'd3);
        send(2, 0, 8'h06, 8'h00);             expect_quiet("R6", 3'd3);
        send(2, 0, 8'h08, 8'h01);             expect_quiet("R6", 3'd3);
        send(2, 0, 8'h0E, exp_chip);          expect_id("R6", 3'd2);
        send(1, 0, 8'h0F);                    expect_quiet("R7", 3'd4);
        send(2, 0, 8'h06, 8'h00);             expect_quiet("R7", 3'd4);
        send(2, 0, 8'h0E, exp_chip);          expect_quiet("R7", 3'd4);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ready_ignores();
        t_wake();
        t_slots();
        t_select();
        t_memory();
        t_lifecycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule